// File: doc/BRIEF.md
# SPI Write Data Packetizer

This block drives the data phase of a long-form DMA write over a byte-wide serial link. The command phase has already been accepted when it is started. It then takes the payload from a valid/ready byte stream and cuts it into packets. Each packet goes out behind a one-byte header that tells the far end whether the packet is the first, an inner one or the final one. When checksum protection is on, a 16-bit CRC trails every packet.

No acknowledgement is awaited between packets. After the final packet the block clocks in exactly four bytes. It locates the response that belongs to the final packet by searching that window backwards, because the window may still hold part of the acknowledgement for the packet before it. The block then reports completion, with an error flag, as a one-cycle pulse.

The packet size comes in as a 3-bit code, the log2 of the size minus 8, taken straight from the link's protocol configuration field. The byte port toward the serial shifter is a request/ready pair. A separate flag marks bytes that are clocked in. Payload bytes pass from the input stream to the shifter with no buffering.

Top module: `spiw_packetizer`

## Requirements
- R1: The payload of `total_len` bytes is sent as packets of 2^(8+`size_code`) bytes each, and a shorter remainder packet closes the transfer when the length is not a multiple of that size.
- R2: Every packet is preceded by a header byte with upper nibble 0xF. Its lower nibble is 1 for the first packet, 2 for an inner packet and 3 for the final packet. A transfer that fits in one packet uses 3.
- R3: With `crc_en` set, each packet's last data byte is followed by the CRC-16 of that packet's data bytes (polynomial 0x1021, preset 0xFFFF, no reflection, no final XOR), high byte first. With `crc_en` clear, no CRC bytes are sent.
- R4: No byte is read between packets. After the final packet, including its CRC, exactly four bytes are read, each with `spi_rd` high and `spi_wdata` equal to 0x00.
- R5: The four read bytes are indexed 0 to 3 in arrival order. The response byte is the one with the highest index among 0, 1 and 2 whose upper nibble is 0xC. Index 3 is never taken as the response byte.
- R6: The transfer succeeds only if the response byte's lower nibble is 3 and the byte following it is 0x00. Otherwise, or when no response byte exists, `err` is raised.
- R7: `done` is a one-cycle pulse in the cycle after the fourth read handshake. `err` is only ever high together with `done`.
- R8: `size_code` values 6 and 7 select the largest packet size, 8192 bytes.
- R9: `total_len`, `size_code` and `crc_en` are captured when `start` is taken in the idle state. Changes to them during a transfer, and `start` pulses during a transfer, have no effect.
- R10: A `start` with `total_len` of 0 gives `done` and `err` in the next cycle, with no traffic on the byte port.
- R11: A payload byte is consumed (`in_valid` and `in_ready` both high) only while it is presented as a write on the byte port that `spi_rdy` accepts in the same cycle, so the bytes reach the port unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a data phase (taken only when idle) |
| total_len | input | LEN_W | Payload length in bytes |
| size_code | input | CODE_W | Packet size code, log2(size) minus 8 |
| crc_en | input | 1 | Append a CRC-16 to every packet |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted when in_valid is also high |
| spi_req | output | 1 | Byte exchange requested on the shifter port |
| spi_rd | output | 1 | Current exchange is a read of a response byte |
| spi_wdata | output | 8 | Byte to shift out |
| spi_rdy | input | 1 | Shifter completes the requested exchange this cycle |
| spi_rdata | input | 8 | Byte shifted in, valid with a read handshake |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Transfer failed, valid with done |

## Verification
The bench sends transfers that fit in one packet, fill exactly one or two packets, and spread over three packets with a short tail. These separate header ordering faults from faults in the remainder count. Each transfer runs with the CRC both on and off, and with gaps on the payload stream and on the shifter ready. This shows whether bytes are dropped or repeated and whether the CRC spans only its own packet. The response windows place a stale acknowledgement ahead of the real one, hide a valid-looking byte in the unscanned last slot, and carry a wrong type nibble or a nonzero status, so the backward scan and both success checks are each tested in isolation. Out-of-range size codes, zero length, and inputs changed during a transfer cover the remaining corner cases.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    localparam logic [3:0] HDR_TAG   = 4'hF;
    localparam logic [3:0] RSP_TAG   = 4'hC;
    localparam logic [3:0] ORD_FIRST = 4'd1;
    localparam logic [3:0] ORD_INNER = 4'd2;
    localparam logic [3:0] ORD_LAST  = 4'd3;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_CRCH,
        ST_CRCL,
        ST_RSP
    } pst_e;

    // One byte through the CCITT polynomial, most significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                               input logic [7:0]  b);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16
    import pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = CRC_PRESET;
        end else if (upd) begin
            crc_d = crc16_byte(crc_q, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/pkt_sizer.sv
module pkt_sizer
    import pkt_pkg::*;
#(
    parameter int LEN_W   = 24,
    parameter int CODE_W  = 3,
    parameter int MIN_LOG = 8,
    parameter int MAX_LOG = 13
) (
    input  logic [CODE_W-1:0] code,
    input  logic [LEN_W-1:0]  rem,
    input  logic              first,
    output logic [LEN_W-1:0]  chunk,
    output logic              last,
    output logic [3:0]        order
);
    localparam int MAX_CODE = MAX_LOG - MIN_LOG;

    logic [CODE_W-1:0] eff;
    logic [LEN_W-1:0]  psize;

    always_comb begin
        eff   = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        psize = LEN_W'(1) << (int'(eff) + MIN_LOG);
        last  = (rem <= psize);
        chunk = last ? rem : psize;
        order = last ? ORD_LAST : (first ? ORD_FIRST : ORD_INNER);
    end
endmodule

// File: rtl/rsp_scan.sv
module rsp_scan
    import pkt_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic [NB*8-1:0] bytes,
    output logic            ok
);
    localparam int NS = NB - 1;

    logic [NS-1:0] hit;
    logic          found;
    logic [3:0]    sel_lo;
    logic [7:0]    sel_nx;

    for (genvar g = 0; g < NS; g++) begin : g_hit
        assign hit[g] = (bytes[g*8+4 +: 4] == RSP_TAG);
    end

    // Ascending walk: the highest matching index is the one that sticks.
    always_comb begin
        found  = 1'b0;
        sel_lo = 4'h0;
        sel_nx = 8'h00;
        for (int i = 0; i < NS; i++) begin
            if (hit[i]) begin
                found  = 1'b1;
                sel_lo = bytes[i*8 +: 4];
                sel_nx = bytes[(i+1)*8 +: 8];
            end
        end
        ok = found && (sel_lo == ORD_LAST) && (sel_nx == 8'h00);
    end
endmodule

// File: rtl/spiw_packetizer.sv
module spiw_packetizer
    import pkt_pkg::*;
#(
    parameter int LEN_W   = 24,
    parameter int CODE_W  = 3,
    parameter int MIN_LOG = 8,
    parameter int MAX_LOG = 13,
    parameter int RSP_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  total_len,
    input  logic [CODE_W-1:0] size_code,
    input  logic              crc_en,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              spi_req,
    output logic              spi_rd,
    output logic [7:0]        spi_wdata,
    input  logic              spi_rdy,
    input  logic [7:0]        spi_rdata,
    output logic              done,
    output logic              err
);
    localparam int IDX_W = $clog2(RSP_N);
    localparam int RB_W  = RSP_N * 8;

    typedef struct packed {
        pst_e              state;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  pkt_left;
        logic [CODE_W-1:0] code;
        logic              crc_on;
        logic              first;
        logic [IDX_W-1:0]  idx;
        logic [RB_W-1:0]   rbuf;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t q, d;

    logic [LEN_W-1:0] chunk;
    logic             pkt_last;
    logic [3:0]       order;
    logic [15:0]      crc_val;
    logic             crc_clr;
    logic             crc_upd;
    logic [RB_W-1:0]  rsp_view;
    logic             rsp_ok;

    pkt_sizer #(
        .LEN_W  (LEN_W),
        .CODE_W (CODE_W),
        .MIN_LOG(MIN_LOG),
        .MAX_LOG(MAX_LOG)
    ) u_sizer (
        .code (q.code),
        .rem  (q.rem),
        .first(q.first),
        .chunk(chunk),
        .last (pkt_last),
        .order(order)
    );

    pkt_crc16 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (crc_clr),
        .upd  (crc_upd),
        .din  (in_data),
        .crc  (crc_val)
    );

    // Window as it stands once the byte now arriving is in the last slot.
    always_comb begin
        rsp_view = q.rbuf;
        rsp_view[RB_W-8 +: 8] = spi_rdata;
    end

    rsp_scan #(.NB(RSP_N)) u_scan (
        .bytes(rsp_view),
        .ok   (rsp_ok)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        spi_req   = 1'b0;
        spi_rd    = 1'b0;
        spi_wdata = 8'h00;
        in_ready  = 1'b0;
        crc_clr   = 1'b0;
        crc_upd   = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (total_len == '0) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.state  = ST_HDR;
                        d.rem    = total_len;
                        d.code   = size_code;
                        d.crc_on = crc_en;
                        d.first  = 1'b1;
                    end
                end
            end
            ST_HDR: begin
                spi_req   = 1'b1;
                spi_wdata = {HDR_TAG, order};
                if (spi_rdy) begin
                    d.pkt_left = chunk;
                    d.first    = 1'b0;
                    d.state    = ST_DATA;
                    crc_clr    = 1'b1;
                end
            end
            ST_DATA: begin
                spi_req   = in_valid;
                spi_wdata = in_data;
                in_ready  = spi_rdy;
                if (in_valid && spi_rdy) begin
                    crc_upd    = 1'b1;
                    d.rem      = q.rem - 1'b1;
                    d.pkt_left = q.pkt_left - 1'b1;
                    if (q.pkt_left == LEN_W'(1)) begin
                        d.idx = '0;
                        if (q.crc_on)            d.state = ST_CRCH;
                        else if (q.rem == LEN_W'(1)) d.state = ST_RSP;
                        else                     d.state = ST_HDR;
                    end
                end
            end
            ST_CRCH: begin
                spi_req   = 1'b1;
                spi_wdata = crc_val[15:8];
                if (spi_rdy) d.state = ST_CRCL;
            end
            ST_CRCL: begin
                spi_req   = 1'b1;
                spi_wdata = crc_val[7:0];
                if (spi_rdy) begin
                    d.idx   = '0;
                    d.state = (q.rem == '0) ? ST_RSP : ST_HDR;
                end
            end
            ST_RSP: begin
                spi_req = 1'b1;
                spi_rd  = 1'b1;
                if (spi_rdy) begin
                    d.rbuf[{q.idx, 3'b000} +: 8] = spi_rdata;
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IDX_W'(RSP_N - 1)) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.err   = !rsp_ok;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign err  = q.err;
endmodule

// File: rtl/pkt_chk.sv
module pkt_chk #(
    parameter int RSP_N = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       spi_req,
    input logic       spi_rd,
    input logic [7:0] spi_wdata,
    input logic       spi_rdy,
    input logic       done,
    input logic       err
);
    logic [7:0] rd_cnt_d, rd_cnt_q;

    always_comb begin
        rd_cnt_d = rd_cnt_q;
        if (done) rd_cnt_d = '0;
        else if (spi_req && spi_rd && spi_rdy) rd_cnt_d = rd_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cnt_q <= '0;
        else        rd_cnt_q <= rd_cnt_d;
    end

    // R4
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && spi_rd) |-> (spi_wdata == 8'h00));

    // R4
    four_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_cnt_q == 8'(RSP_N) || rd_cnt_q == 8'd0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R7
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !spi_req);

    // R11
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (spi_req && spi_rdy && !spi_rd && spi_wdata == in_data));
endmodule

bind spiw_packetizer pkt_chk #(.RSP_N(RSP_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .spi_req  (spi_req),
    .spi_rd   (spi_rd),
    .spi_wdata(spi_wdata),
    .spi_rdy  (spi_rdy),
    .done     (done),
    .err      (err)
);

// File: tb/sim_spiw_packetizer.sv
module sim_spiw_packetizer;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W  = 24;
    localparam int CODE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [LEN_W-1:0]  total_len;
    logic [CODE_W-1:0] size_code;
    logic              crc_en;
    logic              in_valid;
    logic [7:0]        in_data;
    logic              in_ready;
    logic              spi_req;
    logic              spi_rd;
    logic [7:0]        spi_wdata;
    logic              spi_rdy;
    logic [7:0]        spi_rdata;
    logic              done;
    logic              err;

    always #(CLK_PERIOD/2) clk = ~clk;

    spiw_packetizer #(.LEN_W(LEN_W), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .size_code(size_code), .crc_en(crc_en), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .spi_req(spi_req),
        .spi_rd(spi_rd), .spi_wdata(spi_wdata), .spi_rdy(spi_rdy),
        .spi_rdata(spi_rdata), .done(done), .err(err)
    );

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    logic [7:0] exp_q[$];
    logic [7:0] pay_q[$];
    logic [7:0] rsp_b[4];
    int         nreads;
    logic       exp_err;
    logic       done_due;
    logic       done_seen;
    logic       start_pulse;
    int         vmode, rmode;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [7:0] b);
        logic [15:0] c = c0;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ b[i]) c = (c << 1) ^ 16'h1021;
            else              c = c << 1;
        end
        return c;
    endfunction

    // Expected outcome of a response window: highest index 0..2 with tag 0xC.
    function automatic logic ref_err(input logic [7:0] r0, input logic [7:0] r1,
                                     input logic [7:0] r2, input logic [7:0] r3);
        logic [7:0] w[4];
        w[0] = r0; w[1] = r1; w[2] = r2; w[3] = r3;
        for (int i = 2; i >= 0; i--) begin
            if (w[i][7:4] == 4'hC) return !(w[i][3:0] == 4'h3 && w[i+1] == 8'h00);
        end
        return 1'b1;
    endfunction

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > 190000) begin
            chk(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
        start = start_pulse;
        start_pulse = 1'b0;
        case (rmode)
            1:       spi_rdy = (cyc % 3) != 0;
            2:       spi_rdy = (cyc % 5) >= 2;
            default: spi_rdy = 1'b1;
        endcase
        case (vmode)
            1:       in_valid = ((cyc % 4) != 1) && (pay_q.size() > 0);
            2:       in_valid = ((cyc % 7) < 3) && (pay_q.size() > 0);
            default: in_valid = pay_q.size() > 0;
        endcase
        in_data   = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
        spi_rdata = rsp_b[(nreads < 4) ? nreads : 0];
        #1;
        // R7: done exactly when due, err with it
        if (done_due) begin
            chk(done === 1'b1, "R7 done pulse", done, 1);
            chk(err === exp_err, "R6 err result", err, exp_err);
            done_due  = 1'b0;
            done_seen = 1'b1;
        end else begin
            chk(done === 1'b0, "R7 stray done", done, 0);
        end
        if (spi_req && spi_rdy) begin
            if (spi_rd) begin
                chk(exp_q.size() == 0, "R4 read before stream end", exp_q.size(), 0);
                chk(spi_wdata === 8'h00, "R4 read fill byte", spi_wdata, 0);
                chk(nreads < 4, "R4 read count", nreads + 1, 4);
                nreads++;
                if (nreads == 4) done_due = 1'b1;
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R1 extra write byte", spi_wdata, 0);
            end else begin
                chk(spi_wdata === exp_q[0], "R1/R2/R3 write byte", spi_wdata, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        if (in_valid && in_ready) begin
            // R11: consumption only with an accepted write of the same byte
            chk(spi_req && spi_rdy && !spi_rd && spi_wdata === in_data,
                "R11 pass-through", spi_wdata, in_data);
            void'(pay_q.pop_front());
        end
    endtask

    task automatic run_case(input int len, input int code, input logic crc,
                            input logic [7:0] r0, input logic [7:0] r1,
                            input logic [7:0] r2, input logic [7:0] r3,
                            input int vm, input int rm, input logic poke);
        int psize, rem, n, seed;
        logic first;
        logic [15:0] c;
        logic [7:0] b;
        exp_q.delete();
        pay_q.delete();
        psize = 1 << (8 + ((code > 5) ? 5 : code));
        seed  = len * 3 + code;
        for (int k = 0; k < len; k++) pay_q.push_back(8'((k * 7 + seed) & 255));
        rem = len; first = 1'b1; n = 0;
        while (rem > 0) begin
            int cnt = (rem <= psize) ? rem : psize;
            exp_q.push_back({4'hF, (rem <= psize) ? 4'd3 : (first ? 4'd1 : 4'd2)});
            c = 16'hFFFF;
            for (int k = 0; k < cnt; k++) begin
                b = 8'((n * 7 + seed) & 255);
                exp_q.push_back(b);
                c = ref_crc(c, b);
                n++;
            end
            if (crc) begin
                exp_q.push_back(c[15:8]);
                exp_q.push_back(c[7:0]);
            end
            rem -= cnt; first = 1'b0;
        end
        rsp_b[0] = r0; rsp_b[1] = r1; rsp_b[2] = r2; rsp_b[3] = r3;
        nreads    = 0;
        exp_err   = (len == 0) ? 1'b1 : ref_err(r0, r1, r2, r3);
        done_seen = 1'b0;
        vmode = vm; rmode = rm;
        total_len = LEN_W'(len);
        size_code = CODE_W'(code);
        crc_en    = crc;
        start_pulse = 1'b1;
        tick();
        if (len == 0) done_due = 1'b1;
        for (int t = 0; t < 40000 && !done_seen; t++) begin
            if (poke && t == 20) begin
                // R9: inputs changed and start repeated mid-transfer
                start_pulse = 1'b1;
                total_len   = LEN_W'(5);
                size_code   = CODE_W'(code + 1);
                crc_en      = !crc;
            end
            tick();
        end
        chk(done_seen, "R7 transfer completed", done_seen, 1);
        chk(exp_q.size() == 0, "R1 bytes left unsent", exp_q.size(), 0);
        chk(nreads == ((len == 0) ? 0 : 4), "R4 reads per transfer", nreads, 4);
        // R9/R10: port stays quiet afterwards
        for (int t = 0; t < 4; t++) begin
            tick();
            chk(!spi_req, "R9 idle after done", spi_req, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; start_pulse = 1'b0;
        total_len = '0; size_code = '0; crc_en = 1'b0;
        in_valid = 1'b0; in_data = 8'h00; spi_rdy = 1'b0; spi_rdata = 8'h00;
        done_due = 1'b0; done_seen = 1'b0; nreads = 0; exp_err = 1'b0;
        vmode = 0; rmode = 0;
        rsp_b[0] = 0; rsp_b[1] = 0; rsp_b[2] = 0; rsp_b[3] = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!done && !err, "R7 reset state done/err", done, 0);
        chk(!spi_req && !in_ready, "R11 reset state port", spi_req, 0);
        rst_n = 1'b1;
        // R2 single short packet marked last; R6 response at index 0
        run_case(100, 0, 1'b0, 8'hC3, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        // R1 R2 R3 three packets with tail, stale ack ahead (R5 index 2)
        run_case(600, 0, 1'b1, 8'hC2, 8'h00, 8'hC3, 8'h00, 1, 1, 0);
        // R1 R2 exact two packets, first then last
        run_case(512, 0, 1'b0, 8'h00, 8'hC3, 8'h00, 8'h11, 2, 2, 0);
        // R2 exactly one packet
        run_case(256, 0, 1'b1, 8'hC3, 8'h00, 8'hC3, 8'h00, 0, 1, 0);
        // R1 512-byte packets, R9 mid-transfer changes ignored
        run_case(700, 1, 1'b1, 8'h00, 8'h00, 8'hC3, 8'h00, 1, 0, 1);
        // R5 byte at index 3 never scanned
        run_case(40, 0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hC3, 0, 2, 0);
        // R6 wrong type nibble
        run_case(40, 0, 1'b1, 8'hC2, 8'h00, 8'h00, 8'h00, 2, 0, 0);
        // R6 nonzero status after response
        run_case(40, 0, 1'b0, 8'hC3, 8'h05, 8'h00, 8'h00, 0, 0, 0);
        // R5 later match wins over an earlier good one
        run_case(30, 0, 1'b0, 8'hC3, 8'h00, 8'hC1, 8'h00, 0, 0, 0);
        // R8 out-of-range code selects 8192
        run_case(8200, 7, 1'b0, 8'hC3, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        // R10 zero length
        run_case(0, 0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        finish_run();
    end
endmodule